// File: doc/BRIEF.md
# Retransmitting Four-Buffer Packet Transmitter

This block is the sending half of a link that recovers from corrupted packets without the far end ever asking for a resend. An upstream source writes 32-bit words into one of four packet buffers and closes each buffer with an end-of-packet strobe and a 4-bit title. The sender moves through the filled buffers in a circle. It keeps transmitting each one, over and over, until an acknowledge naming that buffer comes back. When nothing is waiting, it keeps the line busy with idle service packets. The output is a continuous stream of 32-bit words, one per clock.

Every packet is 260 words long. Word 0 is a header. Word 1 is the bitwise inverse of the header, so a corrupted buffer number can be detected before any payload is steered. Words 2 to 257 are a fixed 256-word payload. Word 258 is a flags word holding the number of words the source actually wrote. Word 259 is an XOR checksum. A short write is never shifted: the words sit at the start of the payload and the rest is sent as zero.

Line coding, the transceiver and clock-domain crossing sit outside this block.

Top module: `retx_quad_sender`

## Requirements
- R1: While reset is low, `src_ready` is 1 and `tx_valid` is 0. On the first clock edge after reset, `tx_valid` goes to 1 and stays at 1, with a new word on `tx_word` every cycle.
- R2: Each packet is 260 words, laid out as follows:
  - word 0 is the header;
  - word 1 is the bitwise inverse of word 0;
  - words 2 to 257 are the payload;
  - word 258 is the flags word;
  - word 259 is the XOR of words 2 to 258.
- R3: Header fields:
  - bits [1:0] hold the buffer index;
  - bits [7:4] hold the title latched at that buffer's end-of-packet;
  - bit 8 is 1 for a data packet and 0 for a service packet;
  - all other bits are 0.
- R4: When no buffer is filled at a packet start, a service packet is sent. Its header, payload, flags and checksum words are all 0, so word 1 is all ones.
- R5: The source fills buffers strictly in the order 0, 1, 2, 3 and then wraps. `src_ready` is 1 only when the next buffer in that order is free and is not the buffer whose packet is currently on the line.
- R6: A buffer closed after N accepted writes (1 to 256) carries those words in write order in payload words 0 to N-1, zeros in the remaining payload words, and N in the flags word. Writes beyond the 256th before end-of-packet are dropped.
- R7: At each packet start, the sender picks the first filled buffer after the one it sent last, counting upward and wrapping from 3 to 0.
- R8: A filled buffer keeps being resent until an acknowledge with its index arrives. The acknowledge frees only that buffer, and the buffer is never sent again.
- R9: An acknowledge that arrives while its buffer's packet is on the line does not cut that packet short. The packet completes with all 260 words unchanged.
- R10: A write or end-of-packet presented while `src_ready` is 0 is ignored and leaves every buffer's contents, length and title unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Source word write strobe |
| wr_data | input | 32 | Source word |
| wr_eop | input | 1 | Closes the buffer being filled |
| wr_title | input | 4 | Title latched with end-of-packet |
| ack_valid | input | 1 | Acknowledge pulse from the far end |
| ack_idx | input | 2 | Buffer index being acknowledged |
| src_ready | output | 1 | Next buffer in fill order may be written |
| tx_valid | output | 1 | Output word is valid |
| tx_word | output | 32 | Serial packet word stream |

## Verification
The assertions take for granted two things about the inputs. First, the source opens a buffer only through end-of-packet accepted with `src_ready` high. Second, an acknowledge only ever names an index in range. The bench keeps within both. It waits for `src_ready` before every fill, and it pulses acknowledges only for buffers it has itself filled. It also times every multi-buffer fill just after a packet boundary, so all four buffers are full before the next pick and the circular order is fixed. The ignored-write case is driven on purpose while `src_ready` is low. Its absence of effect is then read back through the next packets of the affected buffer.

// File: rtl/rqs_pkg.sv
package rqs_pkg;
   // Header layout shared by framer and checker
   localparam int TITLE_W       = 4;
   localparam int HDR_TITLE_LSB = 4;
   localparam int HDR_TYPE_BIT  = 8;
   // Header, header inverse, flags word, payload checksum
   localparam int OVERHEAD      = 4;
endpackage

// File: rtl/rqs_store.sv
module rqs_store
   import rqs_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int NBUF      = 4,
   parameter int PKT_WORDS = 256
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [DATA_W-1:0]              wr_data,
   input  logic                           wr_eop,
   input  logic [TITLE_W-1:0]             wr_title,
   input  logic                           ack_valid,
   input  logic [$clog2(NBUF)-1:0]        ack_idx,
   input  logic                           busy_valid,
   input  logic [$clog2(NBUF)-1:0]        busy_idx,
   input  logic [$clog2(NBUF)-1:0]        rd_buf,
   input  logic [$clog2(PKT_WORDS)-1:0]   rd_word,
   output logic [NBUF-1:0]                full_o,
   output logic                           src_ready,
   output logic [DATA_W-1:0]              rd_data,
   output logic [TITLE_W-1:0]             rd_title,
   output logic [$clog2(PKT_WORDS):0]     rd_len
);
   localparam int IDX_W  = $clog2(NBUF);
   localparam int WIDX_W = $clog2(PKT_WORDS);
   localparam int CNT_W  = WIDX_W + 1;

   logic [DATA_W-1:0]  mem_q   [NBUF][PKT_WORDS];
   logic [CNT_W-1:0]   len_q   [NBUF];
   logic [TITLE_W-1:0] title_q [NBUF];
   logic [IDX_W-1:0]   wr_ptr_q;
   logic [CNT_W-1:0]   wcnt_q;
   logic               room;
   logic               wr_fire;
   logic               eop_fire;

   // Count below PKT_WORDS (a power of two) while top bit is clear
   assign room      = ~wcnt_q[CNT_W-1];
   assign src_ready = ~full_o[wr_ptr_q] & ~(busy_valid && (busy_idx == wr_ptr_q));
   assign wr_fire   = wr_en && src_ready && room;
   assign eop_fire  = wr_eop && src_ready;

   always_ff @(posedge clk) begin
      if (wr_fire) begin
         mem_q[wr_ptr_q][wcnt_q[WIDX_W-1:0]] <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         wcnt_q   <= '0;
         for (int i = 0; i < NBUF; i++) begin
            len_q[i]   <= '0;
            title_q[i] <= '0;
         end
      end else if (eop_fire) begin
         len_q[wr_ptr_q]   <= wcnt_q + CNT_W'(wr_fire);
         title_q[wr_ptr_q] <= wr_title;
         wr_ptr_q          <= wr_ptr_q + 1'b1;
         wcnt_q            <= '0;
      end else if (wr_fire) begin
         wcnt_q <= wcnt_q + 1'b1;
      end
   end

   // One occupancy flag per buffer; filling wins over a stale acknowledge
   for (genvar b = 0; b < NBUF; b++) begin : g_flag
      logic f_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            f_q <= 1'b0;
         end else if (eop_fire && (wr_ptr_q == IDX_W'(b))) begin
            f_q <= 1'b1;
         end else if (ack_valid && (ack_idx == IDX_W'(b))) begin
            f_q <= 1'b0;
         end
      end
      assign full_o[b] = f_q;
   end

   // Words past the written length read as zero: no clearing pass is needed
   assign rd_len   = len_q[rd_buf];
   assign rd_title = title_q[rd_buf];
   assign rd_data  = ({1'b0, rd_word} < rd_len) ? mem_q[rd_buf][rd_word] : '0;
endmodule

// File: rtl/rqs_pick.sv
module rqs_pick #(
   parameter int NBUF = 4
) (
   input  logic [NBUF-1:0]          full,
   input  logic [$clog2(NBUF)-1:0]  last,
   output logic                     any,
   output logic [$clog2(NBUF)-1:0]  sel
);
   localparam int IDX_W = $clog2(NBUF);

   // Walk downward so the closest successor of 'last' is the final hit
   always_comb begin
      logic [IDX_W-1:0] cand;
      any = 1'b0;
      sel = last;
      for (int k = NBUF; k >= 1; k--) begin
         cand = last + IDX_W'(k);
         if (full[cand]) begin
            any = 1'b1;
            sel = cand;
         end
      end
   end
endmodule

// File: rtl/rqs_framer.sv
module rqs_framer
   import rqs_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int NBUF      = 4,
   parameter int PKT_WORDS = 256
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           pick_any,
   input  logic [$clog2(NBUF)-1:0]        pick_sel,
   input  logic [DATA_W-1:0]              rd_data,
   input  logic [TITLE_W-1:0]             rd_title,
   input  logic [$clog2(PKT_WORDS):0]     rd_len,
   output logic [$clog2(NBUF)-1:0]        rd_buf,
   output logic [$clog2(PKT_WORDS)-1:0]   rd_word,
   output logic [$clog2(NBUF)-1:0]        last_idx,
   output logic                           busy_valid,
   output logic [$clog2(NBUF)-1:0]        busy_idx,
   output logic                           tx_valid,
   output logic [DATA_W-1:0]              tx_word
);
   localparam int IDX_W    = $clog2(NBUF);
   localparam int WIDX_W   = $clog2(PKT_WORDS);
   localparam int PKT_LEN  = PKT_WORDS + OVERHEAD;
   localparam int POS_W    = $clog2(PKT_LEN);
   localparam int FLAG_POS = PKT_WORDS + 2;
   localparam int SUM_POS  = PKT_WORDS + 3;

   logic [POS_W-1:0]  pos_q;
   logic [DATA_W-1:0] hdr_q;
   logic [DATA_W-1:0] csum_q;
   logic [IDX_W-1:0]  cur_idx_q;
   logic              cur_data_q;
   logic [IDX_W-1:0]  last_q;
   logic [DATA_W-1:0] hdr_new;
   logic [DATA_W-1:0] word;
   logic              at_start;

   assign at_start   = (pos_q == '0);
   assign rd_buf     = at_start ? pick_sel : cur_idx_q;
   assign rd_word    = WIDX_W'(pos_q - POS_W'(2));
   assign last_idx   = last_q;
   assign busy_valid = cur_data_q;
   assign busy_idx   = cur_idx_q;

   always_comb begin
      hdr_new = '0;
      if (pick_any) begin
         hdr_new[IDX_W-1:0]                   = pick_sel;
         hdr_new[HDR_TITLE_LSB +: TITLE_W]    = rd_title;
         hdr_new[HDR_TYPE_BIT]                = 1'b1;
      end
   end

   always_comb begin
      if (at_start) begin
         word = hdr_new;
      end else if (pos_q == POS_W'(1)) begin
         word = ~hdr_q;
      end else if (pos_q < POS_W'(FLAG_POS)) begin
         word = cur_data_q ? rd_data : '0;
      end else if (pos_q == POS_W'(FLAG_POS)) begin
         word = cur_data_q ? DATA_W'(rd_len) : '0;
      end else begin
         word = csum_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q      <= '0;
         hdr_q      <= '0;
         csum_q     <= '0;
         cur_idx_q  <= '0;
         cur_data_q <= 1'b0;
         last_q     <= IDX_W'(NBUF - 1);
         tx_valid   <= 1'b0;
         tx_word    <= '0;
      end else begin
         tx_valid <= 1'b1;
         tx_word  <= word;
         pos_q    <= (pos_q == POS_W'(SUM_POS)) ? '0 : pos_q + 1'b1;
         if (at_start) begin
            hdr_q      <= hdr_new;
            csum_q     <= '0;
            cur_data_q <= pick_any;
            cur_idx_q  <= pick_any ? pick_sel : '0;
            if (pick_any) begin
               last_q <= pick_sel;
            end
         end else if (pos_q >= POS_W'(2) && pos_q <= POS_W'(FLAG_POS)) begin
            csum_q <= csum_q ^ word;
         end
      end
   end
endmodule

// File: rtl/retx_quad_sender.sv
module retx_quad_sender
   import rqs_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int NBUF      = 4,
   parameter int PKT_WORDS = 256
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic                     wr_eop,
   input  logic [TITLE_W-1:0]       wr_title,
   input  logic                     ack_valid,
   input  logic [$clog2(NBUF)-1:0]  ack_idx,
   output logic                     src_ready,
   output logic                     tx_valid,
   output logic [DATA_W-1:0]        tx_word
);
   localparam int IDX_W  = $clog2(NBUF);
   localparam int WIDX_W = $clog2(PKT_WORDS);
   localparam int CNT_W  = WIDX_W + 1;

   if (NBUF < 2 || (1 << IDX_W) != NBUF || IDX_W > HDR_TITLE_LSB) begin : g_bad_nbuf
      $error("NBUF must be a power of two between 2 and 16");
   end
   if (PKT_WORDS < 2 || (1 << WIDX_W) != PKT_WORDS) begin : g_bad_words
      $error("PKT_WORDS must be a power of two of at least 2");
   end
   if (DATA_W <= HDR_TYPE_BIT || DATA_W < CNT_W) begin : g_bad_width
      $error("DATA_W too narrow for header or length field");
   end

   logic [NBUF-1:0]   full;
   logic              pick_any;
   logic [IDX_W-1:0]  pick_sel;
   logic [IDX_W-1:0]  last_idx;
   logic              busy_valid;
   logic [IDX_W-1:0]  busy_idx;
   logic [IDX_W-1:0]  rd_buf;
   logic [WIDX_W-1:0] rd_word;
   logic [DATA_W-1:0] rd_data;
   logic [TITLE_W-1:0] rd_title;
   logic [CNT_W-1:0]  rd_len;

   rqs_store #(.DATA_W(DATA_W), .NBUF(NBUF), .PKT_WORDS(PKT_WORDS)) i_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .wr_eop     (wr_eop),
      .wr_title   (wr_title),
      .ack_valid  (ack_valid),
      .ack_idx    (ack_idx),
      .busy_valid (busy_valid),
      .busy_idx   (busy_idx),
      .rd_buf     (rd_buf),
      .rd_word    (rd_word),
      .full_o     (full),
      .src_ready  (src_ready),
      .rd_data    (rd_data),
      .rd_title   (rd_title),
      .rd_len     (rd_len)
   );

   rqs_pick #(.NBUF(NBUF)) i_pick (
      .full (full),
      .last (last_idx),
      .any  (pick_any),
      .sel  (pick_sel)
   );

   rqs_framer #(.DATA_W(DATA_W), .NBUF(NBUF), .PKT_WORDS(PKT_WORDS)) i_framer (
      .clk        (clk),
      .rst_n      (rst_n),
      .pick_any   (pick_any),
      .pick_sel   (pick_sel),
      .rd_data    (rd_data),
      .rd_title   (rd_title),
      .rd_len     (rd_len),
      .rd_buf     (rd_buf),
      .rd_word    (rd_word),
      .last_idx   (last_idx),
      .busy_valid (busy_valid),
      .busy_idx   (busy_idx),
      .tx_valid   (tx_valid),
      .tx_word    (tx_word)
   );
endmodule

// File: rtl/rqs_checker.sv
module rqs_checker
   import rqs_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int NBUF      = 4,
   parameter int PKT_WORDS = 256
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     wr_eop,
   input logic                     src_ready,
   input logic                     ack_valid,
   input logic [$clog2(NBUF)-1:0]  ack_idx,
   input logic                     tx_valid,
   input logic [DATA_W-1:0]        tx_word
);
   localparam int IDX_W   = $clog2(NBUF);
   localparam int PKT_LEN = PKT_WORDS + OVERHEAD;
   localparam int POS_W   = $clog2(PKT_LEN);
   localparam logic [DATA_W-1:0] HDR_OK =
      DATA_W'((1 << IDX_W) - 1) | DATA_W'(((1 << TITLE_W) - 1) << HDR_TITLE_LSB) |
      DATA_W'(1 << HDR_TYPE_BIT);

   // Occupancy model built only from port activity
   logic [NBUF-1:0]  sh_full;
   logic [IDX_W-1:0] sh_ptr;
   logic [POS_W-1:0] cpos;
   logic             svc_q;

   always_ff @(posedge clk) begin
      logic [NBUF-1:0] nxt;
      if (!rst_n) begin
         sh_full <= '0;
         sh_ptr  <= '0;
         cpos    <= '0;
         svc_q   <= 1'b0;
      end else begin
         nxt = sh_full;
         if (ack_valid) nxt[ack_idx] = 1'b0;
         if (wr_eop && src_ready) begin
            nxt[sh_ptr] = 1'b1;
            sh_ptr <= sh_ptr + 1'b1;
         end
         sh_full <= nxt;
         if (tx_valid) begin
            cpos <= (cpos == POS_W'(PKT_LEN - 1)) ? '0 : cpos + 1'b1;
            if (cpos == '0) svc_q <= ~tx_word[HDR_TYPE_BIT];
         end
      end
   end

   a_r1_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |=> tx_valid);

   a_r5_ready_only_when_free: assert property (@(posedge clk) disable iff (!rst_n)
      src_ready |-> !sh_full[sh_ptr]);

   a_r2_header_inverse: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && cpos == POS_W'(1)) |-> (tx_word == ~$past(tx_word)));

   a_r3_header_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && cpos == '0) |-> ((tx_word & ~HDR_OK) == '0));

   a_r4_service_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && svc_q && cpos >= POS_W'(2)) |-> (tx_word == '0));
endmodule

bind retx_quad_sender rqs_checker #(
   .DATA_W(DATA_W), .NBUF(NBUF), .PKT_WORDS(PKT_WORDS)
) i_rqs_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_eop    (wr_eop),
   .src_ready (src_ready),
   .ack_valid (ack_valid),
   .ack_idx   (ack_idx),
   .tx_valid  (tx_valid),
   .tx_word   (tx_word)
);

// File: tb/test_retx_quad_sender.sv
module test_retx_quad_sender;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        wr_eop = 1'b0;
   logic [3:0]  wr_title = '0;
   logic        ack_valid = 1'b0;
   logic [1:0]  ack_idx = '0;
   logic        src_ready;
   logic        tx_valid;
   logic [31:0] tx_word;

   int total = 0;
   int bad = 0;
   int pos_tb = 0;
   int pkt_count = 0;
   int valid_drops = 0;
   bit seen_valid = 0;
   logic [31:0] cap [260];
   logic [31:0] pk  [260];

   always #10 clk = ~clk;

   retx_quad_sender i_retx_quad_sender (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_eop(wr_eop),
      .wr_title(wr_title), .ack_valid(ack_valid), .ack_idx(ack_idx),
      .src_ready(src_ready), .tx_valid(tx_valid), .tx_word(tx_word)
   );

   // Packet monitor, sampling away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (seen_valid && !tx_valid) valid_drops++;
         if (tx_valid) begin
            seen_valid = 1;
            cap[pos_tb] = tx_word;
            if (pos_tb == 259) begin
               pk = cap;
               pos_tb = 0;
               pkt_count++;
            end else begin
               pos_tb++;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic next_pkt();
      int c = pkt_count;
      wait (pkt_count != c);
      @(posedge clk);
      #1;
   endtask

   function automatic logic [31:0] hdr(input int idx, input int title);
      return 32'h100 | (32'(title) << 4) | 32'(idx);
   endfunction

   task automatic fill(input int n, input logic [31:0] base, input logic [3:0] t);
      while (!src_ready) step();
      for (int i = 0; i < n; i++) begin
         wr_en = 1'b1;
         wr_data = base + 32'(i);
         step();
      end
      wr_en = 1'b0;
      wr_eop = 1'b1;
      wr_title = t;
      step();
      wr_eop = 1'b0;
   endtask

   task automatic ack(input int idx);
      ack_valid = 1'b1;
      ack_idx = 2'(idx);
      step();
      ack_valid = 1'b0;
   endtask

   // Checks the last captured packet against header, written count and data base
   task automatic chk_pkt(input logic [31:0] h, input int n, input logic [31:0] base, input string ctx);
      logic [31:0] cs = '0;
      logic [31:0] e;
      logic [31:0] ea = '0;
      logic [31:0] aa = '0;
      int mism = -1;
      chk(pk[0] == h, {"R3 header ", ctx}, pk[0], h);
      chk(pk[1] == ~h, {"R2 header inverse ", ctx}, pk[1], ~h);
      for (int i = 0; i < 256; i++) begin
         e = (i < n) ? base + 32'(i) : 32'h0;
         cs ^= e;
         if (pk[2+i] !== e && mism < 0) begin
            mism = i; ea = e; aa = pk[2+i];
         end
      end
      chk(mism < 0, {"R6 payload ", ctx}, aa, ea);
      chk(pk[258] == 32'(n), {"R6 flags ", ctx}, pk[258], 32'(n));
      cs ^= 32'(n);
      chk(pk[259] == cs, {"R2 checksum ", ctx}, pk[259], cs);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) step();
      chk(src_ready == 1'b1, "R1 ready in reset", 32'(src_ready), 32'd1);
      chk(tx_valid == 1'b0, "R1 valid in reset", 32'(tx_valid), 32'd0);
      rst_n = 1'b1;
      step();
      step();
      chk(tx_valid == 1'b1, "R1 valid after reset", 32'(tx_valid), 32'd1);

      // Full 256-word buffer 0 while the first service packet goes out
      fill(256, 32'hA000_0000, 4'h5);
      next_pkt();
      chk_pkt(32'h0, 0, 32'h0, "R4 first service");
      for (int k = 0; k < 3; k++) begin
         next_pkt();
         if (pk[0][8]) break;
      end
      chk_pkt(hdr(0, 5), 256, 32'hA000_0000, "R6 full buf0");
      next_pkt();
      chk_pkt(hdr(0, 5), 256, 32'hA000_0000, "R8 resend buf0");

      // Acknowledge during the packet in flight
      ack(0);
      next_pkt();
      chk_pkt(hdr(0, 5), 256, 32'hA000_0000, "R9 ack in flight buf0");
      next_pkt();
      chk_pkt(32'h0, 0, 32'h0, "R8 freed buf0 not resent");

      // All four buffers, partial lengths, within one service packet
      fill(5, 32'h1000_0000, 4'hA);
      fill(1, 32'h2000_0000, 4'h3);
      fill(200, 32'h3000_0000, 4'hC);
      fill(3, 32'h4000_0000, 4'h7);
      chk(src_ready == 1'b0, "R5 ready low all full", 32'(src_ready), 32'd0);
      wr_en = 1'b1; wr_eop = 1'b1; wr_data = 32'hDEAD_BEEF; wr_title = 4'h9;
      step();
      wr_en = 1'b0; wr_eop = 1'b0;
      next_pkt();
      chk_pkt(32'h0, 0, 32'h0, "R4 service before picks");
      next_pkt(); chk_pkt(hdr(1, 10), 5, 32'h1000_0000, "R7 order buf1");
      next_pkt(); chk_pkt(hdr(2, 3), 1, 32'h2000_0000, "R7 order buf2");
      next_pkt(); chk_pkt(hdr(3, 12), 200, 32'h3000_0000, "R7 order buf3");
      next_pkt(); chk_pkt(hdr(0, 7), 3, 32'h4000_0000, "R10 buf0 untouched");
      next_pkt(); chk_pkt(hdr(1, 10), 5, 32'h1000_0000, "R7 wrap buf1");

      // Buffer 2 is on the line: ack it, next fill slot (1) still full
      ack(2);
      chk(src_ready == 1'b0, "R5 ready low next full", 32'(src_ready), 32'd0);
      next_pkt(); chk_pkt(hdr(2, 3), 1, 32'h2000_0000, "R9 buf2 completes");
      next_pkt(); chk_pkt(hdr(3, 12), 200, 32'h3000_0000, "R8 skip freed buf2");
      next_pkt(); chk_pkt(hdr(0, 7), 3, 32'h4000_0000, "R8 buf0 again");
      // Buffer 1 is now on the line: freeing it must not open it to the source yet
      ack(1);
      step();
      chk(src_ready == 1'b0, "R5 in-flight interlock", 32'(src_ready), 32'd0);
      next_pkt(); chk_pkt(hdr(1, 10), 5, 32'h1000_0000, "R9 buf1 completes");
      step();
      chk(src_ready == 1'b1, "R5 ready after flight ends", 32'(src_ready), 32'd1);

      // Over-long write into buffer 1
      ack(3);
      ack(0);
      fill(260, 32'h5000_0000, 4'hF);
      for (int k = 0; k < 4; k++) begin
         next_pkt();
         if (pk[0] == hdr(1, 15)) break;
      end
      chk_pkt(hdr(1, 15), 256, 32'h5000_0000, "R6 overflow dropped");

      chk(valid_drops == 0, "R1 valid never drops", 32'(valid_drops), 32'd0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule